// File: doc/BRIEF.md
# Supply Monitor Control Register Block

This block is the digital side of an on-chip supply voltage monitor. An analog comparator outside the block reports when the monitored rail has dropped under its threshold. The block carries that level into the clock domain through a synchronizer chain. It then turns the moment the rail goes low into a detection event. A two-bit operating mode selects what the event does. In one mode it requests a power-on reset and also records the event. In another mode it only records the event as a sticky status bit, which can drive an interrupt. The other two codes switch detection off.

Software reaches the block over a small word-addressed register bus. The bus gives access to the control word (mode, trim code, done flag) and to separate write-one-to-set, write-one-to-clear and status-clear registers for the interrupt. After every reset a sequencer issues a single start pulse towards the calibration store. On that pulse it copies the factory trim code from an input into the trim field. It raises a done flag a fixed number of cycles later. Until the flag is set, every bus write is ignored.

Top module: `svmon_ctrl`

## Requirements
- R1: After reset, por_req, irq and cal_done are 0, the mode is 0, the interrupt mask is 0 and the detection status is 0.
- R2: cal_start is high for exactly one cycle, after the first rising clock edge following reset release. The trim field takes the value of cal_default at the next edge. cal_done becomes 1 after edge 2+CAL_LAT counted from release, and stays 1 until the next reset.
- R3: Bus writes to any register have no effect while cal_done is 0.
- R4: Once cal_done is 1, software can overwrite the trim code, which sits at CTRL bits [CAL_W+7:8]. CTRL is at address 0: mode in bits [1:0], done flag in bit 31.
- R5: In mode 1, a change of cmp_low from 0 to 1 gives a one-cycle pulse on por_req. The pulse is visible after the third rising edge that follows the input change, and the detection status is set as well.
- R6: In mode 2, the same change sets the detection status and never raises por_req.
- R7: In mode 0 and mode 3, a change of cmp_low from 0 to 1 leaves both por_req and the detection status at 0.
- R8: Detection fires only on entry into the below-threshold state: while cmp_low stays 1, a cleared status remains 0.
- R9: Writing data bit 0 = 1 to address 1 sets the mask bit, and a write of 0 there leaves the mask unchanged. Writing bit 0 = 1 to address 2 clears the mask. The mask reads at bit 0 of address 3.
- R10: irq is 1 exactly when both the detection status (bit 0 of address 4) and the mask bit are 1.
- R11: Writing bit 0 = 1 to address 5 clears the detection status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| cmp_low | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| cal_default | input | CAL_W | Factory trim code |
| cal_start | output | 1 | One-cycle pulse starting the post-reset calibration load |
| cal_done | output | 1 | Calibration load complete |
| por_req | output | 1 | Power-on reset request pulse |
| irq | output | 1 | Detection interrupt |

## Verification
The hardest window to reach is the short period between reset release and the done flag. During it, the trim field is loaded and bus writes must be dropped. The bench counts clock edges from reset release, issues a full control write in the middle of that window, and reads back the default trim and mode once the flag has risen. A second hard case is a comparator that stays low after the status has been cleared. The bench holds cmp_low high across a status clear and confirms that no new event appears before the line is dropped and raised again.

// File: rtl/svmon_pkg.sv
package svmon_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_RESET = 2'd1,
      MODE_FLAG  = 2'd2,
      MODE_RSVD  = 2'd3
   } mon_mode_e;

   // word addresses on the register bus
   localparam int unsigned ADR_CTRL = 0;
   localparam int unsigned ADR_ISET = 1;
   localparam int unsigned ADR_ICLR = 2;
   localparam int unsigned ADR_MASK = 3;
   localparam int unsigned ADR_STAT = 4;
   localparam int unsigned ADR_SCLR = 5;

   localparam int unsigned TRIM_LSB = 8;

   function automatic logic mode_active(input mon_mode_e m);
      return (m == MODE_RESET) || (m == MODE_FLAG);
   endfunction

endpackage

// File: rtl/svmon_sync.sv
module svmon_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic low_lvl,
   output logic low_evt
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("svmon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              lvl_prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= chain[STAGES-1];
   end

   assign low_lvl = chain[STAGES-1];
   assign low_evt = chain[STAGES-1] & ~lvl_prev;

   // R8
   evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_evt |=> !low_evt);

endmodule

// File: rtl/svmon_cal.sv
module svmon_cal #(
   parameter int unsigned CAL_LAT = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic cal_start,
   output logic cal_done
);

   localparam int unsigned CNT_W = (CAL_LAT < 2) ? 1 : $clog2(CAL_LAT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAL_LAT - 1);

   generate
      if (CAL_LAT < 1) begin : g_bad_lat
         $error("svmon_cal: CAL_LAT must be at least 1");
      end
   endgenerate

   logic             pend_q;
   logic             start_q;
   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b1;
         start_q <= 1'b0;
      end else begin
         start_q <= pend_q;
         pend_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == CNT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cal_start = start_q;
   assign cal_done  = done_q;

   // R2
   start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);
   // R2
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> cal_done);
   // R2
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> !cal_done);

endmodule

// File: rtl/svmon_regs.sv
module svmon_regs
   import svmon_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CAL_W   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              low_evt,
   input  logic              cal_load,
   input  logic              cal_done,
   input  logic [CAL_W-1:0]  cal_default,
   output logic              por_req,
   output logic              irq
);

   localparam int unsigned DONE_BIT = DATA_W - 1;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("svmon_regs: ADDR_W must cover six registers");
      end
      if (TRIM_LSB + CAL_W > DATA_W - 1) begin : g_bad_trim
         $error("svmon_regs: trim field overlaps the done flag");
      end
   endgenerate

   mon_mode_e        mode_q;
   logic [CAL_W-1:0] trim_q;
   logic             mask_q;
   logic             stat_q;
   logic             por_q;
   logic             wr_ok;
   logic             hit_ctrl, hit_iset, hit_iclr, hit_sclr;

   assign wr_ok    = bus_sel & bus_wr & cal_done;
   assign hit_ctrl = wr_ok && (bus_addr == ADDR_W'(ADR_CTRL));
   assign hit_iset = wr_ok && (bus_addr == ADDR_W'(ADR_ISET)) && bus_wdata[0];
   assign hit_iclr = wr_ok && (bus_addr == ADDR_W'(ADR_ICLR)) && bus_wdata[0];
   assign hit_sclr = wr_ok && (bus_addr == ADDR_W'(ADR_SCLR)) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         trim_q <= '0;
      end else if (cal_load) begin
         trim_q <= cal_default;
      end else if (hit_ctrl) begin
         mode_q <= mon_mode_e'(bus_wdata[1:0]);
         trim_q <= bus_wdata[TRIM_LSB +: CAL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= 1'b0;
      else if (hit_iset) mask_q <= 1'b1;
      else if (hit_iclr) mask_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            stat_q <= 1'b0;
      else if (low_evt && mode_active(mode_q)) stat_q <= 1'b1;
      else if (hit_sclr)                     stat_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) por_q <= 1'b0;
      else        por_q <= low_evt && (mode_q == MODE_RESET);
   end

   assign por_req = por_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= stat_q & mask_q;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = stat_q & mask_q;
         // R10
         irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (mask_q && stat_q));
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            ADDR_W'(ADR_CTRL): begin
               bus_rdata[1:0]                = mode_q;
               bus_rdata[TRIM_LSB +: CAL_W]  = trim_q;
               bus_rdata[DONE_BIT]           = cal_done;
            end
            ADDR_W'(ADR_MASK): bus_rdata[0] = mask_q;
            ADDR_W'(ADR_STAT): bus_rdata[0] = stat_q;
            default:           bus_rdata    = '0;
         endcase
      end
   end

   // R5
   por_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |=> !por_req);
   // R6
   por_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |-> ($past(mode_q) == MODE_RESET));
   // R7
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_active(mode_q) && !stat_q) |=> !stat_q);
   // R3
   locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_done && !mask_q) |=> ($stable(mode_q) && !mask_q));
   // R9
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_iset |=> mask_q);

endmodule

// File: rtl/svmon_ctrl.sv
module svmon_ctrl
   import svmon_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CAL_W       = 8,
   parameter int unsigned CAL_LAT     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmp_low,
   input  logic [CAL_W-1:0]  cal_default,
   output logic              cal_start,
   output logic              cal_done,
   output logic              por_req,
   output logic              irq
);

   logic low_lvl;
   logic low_evt;

   svmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (cmp_low),
      .low_lvl (low_lvl),
      .low_evt (low_evt)
   );

   svmon_cal #(.CAL_LAT(CAL_LAT)) u_cal (
      .clk       (clk),
      .rst_n     (rst_n),
      .cal_start (cal_start),
      .cal_done  (cal_done)
   );

   svmon_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CAL_W   (CAL_W),
      .IRQ_REG (IRQ_REG)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .low_evt     (low_evt),
      .cal_load    (cal_start),
      .cal_done    (cal_done),
      .cal_default (cal_default),
      .por_req     (por_req),
      .irq         (irq)
   );

   // R8
   evt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_evt |-> low_lvl);

endmodule

// File: tb/sim_svmon_ctrl.sv
`timescale 1ns/1ps
module sim_svmon_ctrl;

   localparam int unsigned AW = 3;
   localparam int unsigned DW = 32;
   localparam int unsigned CW = 8;
   localparam int unsigned LAT = 8;
   localparam logic [CW-1:0] FACTORY = 8'h5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          cmp_low = 1'b0;
   logic [CW-1:0] cal_default = FACTORY;
   logic          cal_start, cal_done, por_req, irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   string       q_req[$];
   logic [31:0] q_val[$];

   always #10 clk = ~clk;

   svmon_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CAL_W(CW), .CAL_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmp_low(cmp_low), .cal_default(cal_default), .cal_start(cal_start),
      .cal_done(cal_done), .por_req(por_req), .irq(irq)
   );

   // driver side: queue an expected value
   task automatic want(input string req, input logic [31:0] v);
      q_req.push_back(req);
      q_val.push_back(v);
   endtask

   // monitor side: pop the oldest expectation and compare
   task automatic observe(input logic [31:0] act);
      string       r;
      logic [31:0] e;
      r = q_req.pop_front();
      e = q_val.pop_front();
      n_checks++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, e);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input int unsigned a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      tick();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input int unsigned a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input logic [1:0] m, input logic [CW-1:0] t);
      return {1'b1, 15'd0, t, 6'd0, m};
   endfunction

   // settle comparator low, set mode, clear status
   task automatic arm(input logic [1:0] m);
      cmp_low = 1'b0;
      repeat (4) tick();
      bus_write(0, ctrl_word(m, FACTORY));
      bus_write(5, 32'h1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int          por_seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      want("R1 por_req", 0);  observe(por_req);
      want("R1 irq", 0);      observe(irq);
      want("R1 cal_done", 0); observe(cal_done);
      rst_n = 1'b1;
      tick();                                 // edge 1
      want("R2 start pulse", 1); observe(cal_start);
      tick();                                 // edge 2
      want("R2 start single", 0); observe(cal_start);
      // R3 write while locked (edge 3)
      bus_write(0, {16'd0, 8'h33, 6'd0, 2'd1});
      bus_write(1, 32'h1);                    // edge 4
      repeat (5) tick();                      // edges 5..9
      want("R2 done not yet", 0); observe(cal_done);
      tick();                                 // edge 10
      want("R2 done at 2+CAL_LAT", 1); observe(cal_done);
      bus_read(0, rd);
      want("R3 R2 ctrl keeps default trim and mode 0", 32'h8000_5A00); observe(rd);
      bus_read(3, rd);
      want("R3 R1 mask still 0", 0); observe(rd);
      bus_read(4, rd);
      want("R1 status 0", 0); observe(rd);
      // R4 trim overwrite
      bus_write(0, ctrl_word(2'd0, 8'h33));
      bus_read(0, rd);
      want("R4 trim overwrite", 32'h8000_3300); observe(rd);

      // R5 mode 1
      arm(2'd1);
      cmp_low = 1'b1;
      tick(); tick();
      want("R5 por not before third edge", 0); observe(por_req);
      tick();
      want("R5 por pulse", 1); observe(por_req);
      tick();
      want("R5 por one cycle", 0); observe(por_req);
      bus_read(4, rd);
      want("R5 status set", 1); observe(rd);
      want("R10 irq masked off", 0); observe(irq);
      // R9 write zero to set register
      bus_write(1, 32'h0);
      bus_read(3, rd);
      want("R9 zero write ignored", 0); observe(rd);
      bus_write(1, 32'h1);
      bus_read(3, rd);
      want("R9 mask set", 1); observe(rd);
      want("R10 irq on", 1); observe(irq);
      bus_write(2, 32'h1);
      bus_read(3, rd);
      want("R9 mask cleared", 0); observe(rd);
      want("R10 irq off", 0); observe(irq);
      bus_write(1, 32'h1);
      // R11 clear while level held
      bus_write(5, 32'h1);
      bus_read(4, rd);
      want("R11 status cleared", 0); observe(rd);
      want("R10 irq follows clear", 0); observe(irq);
      repeat (6) tick();
      bus_read(4, rd);
      want("R8 no event while held low", 0); observe(rd);

      // R6 mode 2
      arm(2'd2);
      cmp_low = 1'b1;
      por_seen = 0;
      for (int i = 0; i < 6; i++) begin
         tick();
         if (por_req) por_seen++;
      end
      want("R6 no reset request", 0); observe(por_seen);
      bus_read(4, rd);
      want("R6 status set", 1); observe(rd);
      want("R10 irq with mask", 1); observe(irq);

      // R7 mode 0 and mode 3
      for (int m = 0; m < 4; m += 3) begin
         arm(2'(m));
         cmp_low = 1'b1;
         por_seen = 0;
         for (int i = 0; i < 6; i++) begin
            tick();
            if (por_req) por_seen++;
         end
         want("R7 no reset request when off", 0); observe(por_seen);
         bus_read(4, rd);
         want("R7 status stays 0 when off", 0); observe(rd);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule